// File: doc/BRIEF.md
# DDR3 DLL-Off Transition Sequencer

This block is a hardware state machine that takes a running DDR3 memory subsystem from DLL-on to DLL-off operation. On a start pulse it fences the host port and lets the controller drain. It then rewrites two mode registers: termination is switched off first, and then the DRAM DLL is disabled. Next it places the memory in software-requested self-refresh. Inside a quasi-dynamic update window it sets the controller's DLL-off mode flag. It then programs the PHY DLL controls, leaves self-refresh and reopens the host port.

Each stage that waits on an external status has a watchdog. If a wait runs too long, the sequencer parks in a sticky error state. Mode-register writes leave the block through a level request and busy handshake. The surrounding logic must keep the MR1 and MR2 source values and the clock-range flag stable while a sequence runs.

Top module: `dll_off_seq`

## Requirements
- R1: After reset `hif_disable`, `mrw_req`, `sr_sw_req`, `dll_off_mode`, `phy_bypass_hi`, `ac_dll_dis`, every `dx_dll_dis` bit, `done` and `err` are 0, and `sw_done` is 1.
- R2: A `start` pulse sets `hif_disable` to 1. No mode-register write is requested until both pipeline-empty inputs are 1 and the write, low-priority and high-priority queue depths are all zero.
- R3: Exactly three mode-register writes are issued, in this order: address 1 with MR1 bits 9, 6 and 2 cleared; address 2 with MR2 bits 10 and 9 cleared; address 1 with that cleared MR1 plus bit 0 set.
- R4: Each write request rises only while `mrw_busy` is 0. It stays high until `mrw_busy` is seen at 1, and the next step waits for `mrw_busy` to return to 0.
- R5: After the writes, `sr_sw_req` rises. The sequence continues only once `op_mode` is 2'b11 and `sr_type` is 2'b10 (software). Self-refresh with `sr_type` 2'b11 (automatic) leaves `dll_off_mode` at 0 and `sw_done` at 1.
- R6: `dll_off_mode` is set only while `sw_done` is 0. The block drops `sw_done`, waits for `sw_done_ack` to be 0, sets the mode flag, raises `sw_done` and waits for `sw_done_ack` to be 1.
- R7: `phy_bypass_hi` becomes the inverse of `clk_below_100m`, and `ac_dll_dis` and every `dx_dll_dis` bit become 1, all after `dll_off_mode` is 1.
- R8: `sr_sw_req` then falls. Normal operation is recognised on `op_mode` 2'b01, or on `op_mode` 2'b11 together with `sr_type` 2'b11.
- R9: On completion `hif_disable` returns to 0 and `done` is 1, with `err` at 0.
- R10: A wait that lasts `WAIT_LIMIT` cycles sets `err` permanently until reset. `done` never rises and no further step runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the transition sequence |
| mr1_cur | input | MR_W | Present MR1 contents |
| mr2_cur | input | MR_W | Present MR2 contents |
| clk_below_100m | input | 1 | Configuration clock under 100 MHz |
| wr_pipe_empty | input | 1 | Write data pipeline empty |
| rd_pipe_empty | input | 1 | Read data pipeline empty |
| wrq_depth | input | QD_W | Write queue depth |
| lprq_depth | input | QD_W | Low-priority read queue depth |
| hprq_depth | input | QD_W | High-priority read queue depth |
| op_mode | input | 2 | Controller operating mode |
| sr_type | input | 2 | Cause of self-refresh |
| mrw_busy | input | 1 | Mode-register write in progress |
| sw_done_ack | input | 1 | Quasi-dynamic update acknowledge |
| hif_disable | output | 1 | Host port blocked |
| mrw_req | output | 1 | Mode-register write request |
| mrw_addr | output | MRA_W | Mode-register number |
| mrw_data | output | MR_W | Mode-register write value |
| sr_sw_req | output | 1 | Software self-refresh request |
| sw_done | output | 1 | Quasi-dynamic window closed when 1 |
| dll_off_mode | output | 1 | Controller DLL-off mode flag |
| phy_bypass_hi | output | 1 | PHY bypass range select for 100 MHz and above |
| ac_dll_dis | output | 1 | Address/command DLL disable |
| dx_dll_dis | output | LANES | Per byte-lane DLL disable |
| done | output | 1 | Sequence complete |
| err | output | 1 | Watchdog expired |

## Verification
Every status wait is driven by background responders in the bench. The checks therefore key on handshake events and do not rely on fixed cycle counts. The state register feeds `mrw_req` and `sw_done` directly, so a status input accepted at one edge shows its effect on the outputs at the next sample point.

The bench samples only on falling edges, half a cycle after the edge that updates the outputs. It bounds each wait by a cycle limit and reports a wait that runs out. For the watchdog it counts cycles from `start`. It samples `err` well before `WAIT_LIMIT`, where it must still be 0, and again after it, where it must be 1.

// File: rtl/dll_off_pkg.sv
// Package: shared encodings and state type for the DLL-off sequencer.
// Assumes a 2-bit operating-mode and self-refresh-type status from the controller.
package dll_off_pkg;
    localparam logic [1:0] OPM_NORMAL = 2'b01;
    localparam logic [1:0] OPM_SREF   = 2'b11;
    localparam logic [1:0] SRT_SW     = 2'b10;
    localparam logic [1:0] SRT_AUTO   = 2'b11;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DRAIN, ST_MR_PREP, ST_MR_ISSUE, ST_MR_DONE,
        ST_SR_ENTER, ST_QD_OPEN, ST_QD_WRITE, ST_QD_CLOSE,
        ST_PHY_CFG, ST_SR_EXIT, ST_FIN, ST_ERR
    } seq_state_t;
endpackage

// File: rtl/dll_off_status.sv
// Module: decodes the controller status into the three conditions the
// sequencer waits on. Purely combinational; assumes inputs are synchronous.
module dll_off_status
    import dll_off_pkg::*;
#(
    parameter int QD_W = 5
) (
    input  logic            wr_pipe_empty,
    input  logic            rd_pipe_empty,
    input  logic [QD_W-1:0] wrq_depth,
    input  logic [QD_W-1:0] lprq_depth,
    input  logic [QD_W-1:0] hprq_depth,
    input  logic [1:0]      op_mode,
    input  logic [1:0]      sr_type,
    output logic            drained,
    output logic            in_sw_sref,
    output logic            in_normal
);
    // Decode drain, software self-refresh and normal-operation conditions.
    always_comb begin
        drained    = wr_pipe_empty && rd_pipe_empty &&
                     (wrq_depth == '0) && (lprq_depth == '0) && (hprq_depth == '0);
        in_sw_sref = (op_mode == OPM_SREF) && (sr_type == SRT_SW);
        in_normal  = (op_mode == OPM_NORMAL) ||
                     ((op_mode == OPM_SREF) && (sr_type == SRT_AUTO));
    end
endmodule

// File: rtl/dll_off_mrw_gen.sv
// Module: forms the address and value of each of the three mode-register
// writes from the step index. Assumes MR1/MR2 sources stay stable during a run.
module dll_off_mrw_gen #(
    parameter int MR_W  = 16,
    parameter int MRA_W = 3
) (
    input  logic [1:0]       step,
    input  logic [MR_W-1:0]  mr1_cur,
    input  logic [MR_W-1:0]  mr2_cur,
    output logic [MRA_W-1:0] addr,
    output logic [MR_W-1:0]  data
);
    localparam logic [MR_W-1:0] RTT_NOM_MASK = MR_W'((1 << 9) | (1 << 6) | (1 << 2));
    localparam logic [MR_W-1:0] RTT_WR_MASK  = MR_W'((1 << 10) | (1 << 9));
    localparam logic [MR_W-1:0] DLL_DIS_BIT  = MR_W'(1);

    logic [MR_W-1:0] mr1_quiet;

    // Select the register number and value for the current write step.
    always_comb begin
        mr1_quiet = mr1_cur & ~RTT_NOM_MASK;
        case (step)
            2'd0:    begin addr = MRA_W'(1); data = mr1_quiet; end
            2'd1:    begin addr = MRA_W'(2); data = mr2_cur & ~RTT_WR_MASK; end
            default: begin addr = MRA_W'(1); data = mr1_quiet | DLL_DIS_BIT; end
        endcase
    end
endmodule

// File: rtl/dll_off_watchdog.sv
// Module: counts cycles spent in one wait state and flags expiry after
// LIMIT cycles. Restarts on every state change; idle when not waiting.
module dll_off_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    // Advance the wait counter while a wait persists.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (!expired)             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dll_off_seq.sv
// Module: top-level DLL-off transition sequencer. Walks a fixed order of
// drain, mode-register writes, self-refresh entry, quasi-dynamic update,
// PHY DLL programming, self-refresh exit and host reopen. Assumes MR inputs
// and the clock-range flag stay stable from start to done.
module dll_off_seq
    import dll_off_pkg::*;
#(
    parameter int MR_W       = 16,
    parameter int MRA_W      = 3,
    parameter int QD_W       = 5,
    parameter int LANES      = 2,
    parameter int WAIT_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MR_W-1:0]  mr1_cur,
    input  logic [MR_W-1:0]  mr2_cur,
    input  logic             clk_below_100m,
    input  logic             wr_pipe_empty,
    input  logic             rd_pipe_empty,
    input  logic [QD_W-1:0]  wrq_depth,
    input  logic [QD_W-1:0]  lprq_depth,
    input  logic [QD_W-1:0]  hprq_depth,
    input  logic [1:0]       op_mode,
    input  logic [1:0]       sr_type,
    input  logic             mrw_busy,
    input  logic             sw_done_ack,
    output logic             hif_disable,
    output logic             mrw_req,
    output logic [MRA_W-1:0] mrw_addr,
    output logic [MR_W-1:0]  mrw_data,
    output logic             sr_sw_req,
    output logic             sw_done,
    output logic             dll_off_mode,
    output logic             phy_bypass_hi,
    output logic             ac_dll_dis,
    output logic [LANES-1:0] dx_dll_dis,
    output logic             done,
    output logic             err
);
    localparam logic [1:0] LAST_MRW = 2'd2;

    seq_state_t state, state_n;
    logic [1:0] mrw_step;
    logic drained, in_sw_sref, in_normal;
    logic waiting, wd_expired, lane_set;

    dll_off_status #(.QD_W(QD_W)) u_status (
        .wr_pipe_empty(wr_pipe_empty), .rd_pipe_empty(rd_pipe_empty),
        .wrq_depth(wrq_depth), .lprq_depth(lprq_depth), .hprq_depth(hprq_depth),
        .op_mode(op_mode), .sr_type(sr_type),
        .drained(drained), .in_sw_sref(in_sw_sref), .in_normal(in_normal)
    );

    dll_off_mrw_gen #(.MR_W(MR_W), .MRA_W(MRA_W)) u_mrw (
        .step(mrw_step), .mr1_cur(mr1_cur), .mr2_cur(mr2_cur),
        .addr(mrw_addr), .data(mrw_data)
    );

    dll_off_watchdog #(.LIMIT(WAIT_LIMIT)) u_wd (
        .clk(clk), .rst_n(rst_n), .run(waiting),
        .restart(state_n != state), .expired(wd_expired)
    );

    // Mark the states that hold on an external condition.
    always_comb begin
        case (state)
            ST_DRAIN, ST_MR_PREP, ST_MR_ISSUE, ST_MR_DONE, ST_SR_ENTER,
            ST_QD_OPEN, ST_QD_CLOSE, ST_SR_EXIT: waiting = 1'b1;
            default:                             waiting = 1'b0;
        endcase
    end

    // Next-state selection for the transition sequence.
    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:     if (start) state_n = ST_DRAIN;
            ST_DRAIN:    if (drained) state_n = ST_MR_PREP;
            ST_MR_PREP:  if (!mrw_busy) state_n = ST_MR_ISSUE;
            ST_MR_ISSUE: if (mrw_busy) state_n = ST_MR_DONE;
            ST_MR_DONE:  if (!mrw_busy)
                             state_n = (mrw_step == LAST_MRW) ? ST_SR_ENTER : ST_MR_PREP;
            ST_SR_ENTER: if (in_sw_sref) state_n = ST_QD_OPEN;
            ST_QD_OPEN:  if (!sw_done_ack) state_n = ST_QD_WRITE;
            ST_QD_WRITE: state_n = ST_QD_CLOSE;
            ST_QD_CLOSE: if (sw_done_ack) state_n = ST_PHY_CFG;
            ST_PHY_CFG:  state_n = ST_SR_EXIT;
            ST_SR_EXIT:  if (in_normal) state_n = ST_FIN;
            ST_FIN:      if (start) state_n = ST_DRAIN;
            default:     state_n = ST_ERR;
        endcase
        if (waiting && wd_expired && (state_n == state)) state_n = ST_ERR;
    end

    // State register and the write-step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mrw_step <= 2'd0;
        end else begin
            state <= state_n;
            if (state == ST_DRAIN)
                mrw_step <= 2'd0;
            else if (state == ST_MR_DONE && state_n == ST_MR_PREP)
                mrw_step <= mrw_step + 2'd1;
        end
    end

    // Sticky control outputs updated on the transitions that own them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hif_disable   <= 1'b0;
            sr_sw_req     <= 1'b0;
            dll_off_mode  <= 1'b0;
            phy_bypass_hi <= 1'b0;
            ac_dll_dis    <= 1'b0;
        end else begin
            if (state_n == ST_DRAIN && state != ST_DRAIN) hif_disable <= 1'b1;
            if (state == ST_SR_EXIT && state_n == ST_FIN)  hif_disable <= 1'b0;
            if (state == ST_MR_DONE && state_n == ST_SR_ENTER) sr_sw_req <= 1'b1;
            if (state == ST_PHY_CFG) begin
                sr_sw_req     <= 1'b0;
                phy_bypass_hi <= !clk_below_100m;
                ac_dll_dis    <= 1'b1;
            end
            if (state == ST_QD_OPEN && state_n == ST_QD_WRITE) dll_off_mode <= 1'b1;
        end
    end

    assign lane_set = (state == ST_PHY_CFG);

    // One disable flop per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)        dx_dll_dis[g] <= 1'b0;
            else if (lane_set) dx_dll_dis[g] <= 1'b1;
        end
    end

    // Decoded handshake and completion outputs.
    always_comb begin
        mrw_req = (state == ST_MR_ISSUE);
        sw_done = !((state == ST_QD_OPEN) || (state == ST_QD_WRITE));
        done    = (state == ST_FIN);
        err     = (state == ST_ERR);
    end
endmodule

// File: rtl/dll_off_seq_chk.sv
// Module: property checker for the DLL-off sequencer, bound to the top.
module dll_off_seq_chk
    import dll_off_pkg::*;
#(
    parameter int MR_W  = 16,
    parameter int MRA_W = 3,
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hif_disable,
    input logic             mrw_req,
    input logic             mrw_busy,
    input logic             sr_sw_req,
    input logic             sw_done,
    input logic             dll_off_mode,
    input logic             ac_dll_dis,
    input logic [LANES-1:0] dx_dll_dis,
    input logic             done,
    input logic             err
);
    p_mrw_fenced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mrw_req |-> hif_disable);
    p_mrw_idle_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mrw_req) |-> $past(!mrw_busy));
    p_mode_in_sref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_off_mode) |-> sr_sw_req);
    p_mode_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_off_mode) |-> !sw_done);
    p_phy_after_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ac_dll_dis) |-> dll_off_mode && (dx_dll_dis == {LANES{1'b1}}));
    p_reopen_after_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hif_disable) |-> !sr_sw_req && dll_off_mode);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err && !done);
endmodule

bind dll_off_seq dll_off_seq_chk #(.MR_W(MR_W), .MRA_W(MRA_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .hif_disable(hif_disable), .mrw_req(mrw_req),
    .mrw_busy(mrw_busy), .sr_sw_req(sr_sw_req), .sw_done(sw_done),
    .dll_off_mode(dll_off_mode), .ac_dll_dis(ac_dll_dis), .dx_dll_dis(dx_dll_dis),
    .done(done), .err(err)
);

// File: tb/dll_off_seq_test.sv
module dll_off_seq_test;
    localparam int MR_W = 16, MRA_W = 3, QD_W = 5, LANES = 2, WLIM = 64, NV = 4;

    // Vector table: MR1, MR2, slow-clock flag, expected writes, bypass, exit style.
    localparam logic [15:0] V_MR1 [NV] = '{16'hFFFF, 16'h0244, 16'h1A46, 16'h0001};
    localparam logic [15:0] V_MR2 [NV] = '{16'hFFFF, 16'h0600, 16'h0E18, 16'h0000};
    localparam logic        V_SLOW[NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] E_W0  [NV] = '{16'hFDBB, 16'h0000, 16'h1802, 16'h0001};
    localparam logic [15:0] E_W1  [NV] = '{16'hF9FF, 16'h0000, 16'h0818, 16'h0000};
    localparam logic [15:0] E_W2  [NV] = '{16'hFDBB, 16'h0001, 16'h1803, 16'h0001};
    localparam logic        E_BYP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic        V_AUTO_EXIT[NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 0, rst_n = 0, start = 0;
    logic [MR_W-1:0] mr1_cur = '0, mr2_cur = '0;
    logic clk_below_100m = 0, wr_pipe_empty = 0, rd_pipe_empty = 0;
    logic [QD_W-1:0] wrq_depth = '0, lprq_depth = '0, hprq_depth = '0;
    logic [1:0] op_mode = 2'b01, sr_type = 2'b00;
    logic mrw_busy = 0, sw_done_ack = 1;
    logic hif_disable, mrw_req, sr_sw_req, sw_done, dll_off_mode;
    logic phy_bypass_hi, ac_dll_dis, done, err;
    logic [MRA_W-1:0] mrw_addr;
    logic [MR_W-1:0] mrw_data;
    logic [LANES-1:0] dx_dll_dis;

    int checks = 0, errors = 0;
    int n_mrw = 0;
    logic [MRA_W-1:0] log_addr [8];
    logic [MR_W-1:0]  log_data [8];
    logic sw_at_rise = 1, prev_mode = 0, ack_d = 1, finished = 0;

    always #10 clk = ~clk;

    dll_off_seq #(.MR_W(MR_W), .MRA_W(MRA_W), .QD_W(QD_W), .LANES(LANES),
                  .WAIT_LIMIT(WLIM)) uut (.*);

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Mode-register responder: accept a request and hold busy for three cycles.
    initial forever begin
        @(negedge clk);
        if (rst_n && mrw_req && !mrw_busy) begin
            if (n_mrw < 8) begin
                log_addr[n_mrw] = mrw_addr;
                log_data[n_mrw] = mrw_data;
            end
            n_mrw++;
            mrw_busy = 1;
            repeat (3) @(negedge clk);
            mrw_busy = 0;
        end
    end

    // Quasi-dynamic acknowledge follows sw_done after two cycles.
    initial forever begin
        @(negedge clk);
        sw_done_ack = ack_d;
        ack_d = sw_done;
    end

    // Record sw_done at the cycle the mode flag rises.
    initial forever begin
        @(negedge clk);
        if (dll_off_mode && !prev_mode) sw_at_rise = sw_done;
        prev_mode = dll_off_mode;
    end

    task automatic do_reset();
        rst_n = 0; start = 0;
        wr_pipe_empty = 0; rd_pipe_empty = 0;
        wrq_depth = 5'd3; lprq_depth = 5'd1; hprq_depth = 5'd2;
        op_mode = 2'b01; sr_type = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_mrw = 0; sw_at_rise = 1;
    endtask

    task automatic pulse_start();
        start = 1; @(negedge clk); start = 0;
    endtask

    task automatic run_vector(input int i);
        mr1_cur = V_MR1[i]; mr2_cur = V_MR2[i]; clk_below_100m = V_SLOW[i];
        pulse_start();
        repeat (2) @(negedge clk);
        chk(hif_disable == 1, "R2", "host fenced", hif_disable, 1);
        // Partial drain: pipelines empty, one queue still busy.
        wr_pipe_empty = 1; rd_pipe_empty = 1; wrq_depth = 0; lprq_depth = 0;
        repeat (6) @(negedge clk);
        chk(n_mrw == 0 && !mrw_req, "R2", "no write before drain", n_mrw, 0);
        hprq_depth = 0;
        for (int k = 0; k < 300 && !sr_sw_req; k++) @(negedge clk);
        chk(sr_sw_req == 1, "R5", "self-refresh request", sr_sw_req, 1);
        chk(n_mrw == 3, "R3", "write count", n_mrw, 3);
        chk(log_addr[0] == 1 && log_addr[1] == 2 && log_addr[2] == 1, "R3", "write order",
            {log_addr[0], log_addr[1], log_addr[2]}, {3'd1, 3'd2, 3'd1});
        chk(log_data[0] == E_W0[i], "R3", "first MR1 value", log_data[0], E_W0[i]);
        chk(log_data[1] == E_W1[i], "R3", "MR2 value", log_data[1], E_W1[i]);
        chk(log_data[2] == E_W2[i], "R3", "second MR1 value", log_data[2], E_W2[i]);
        // Automatic self-refresh must not satisfy the entry wait.
        op_mode = 2'b11; sr_type = 2'b11;
        repeat (8) @(negedge clk);
        chk(dll_off_mode == 0 && sw_done == 1, "R5", "auto self-refresh ignored",
            {dll_off_mode, sw_done}, 2'b01);
        sr_type = 2'b10;
        for (int k = 0; k < 300 && !ac_dll_dis; k++) @(negedge clk);
        chk(dll_off_mode == 1, "R6", "mode flag set", dll_off_mode, 1);
        chk(sw_at_rise == 0, "R6", "flag set inside window", sw_at_rise, 0);
        chk(phy_bypass_hi == E_BYP[i], "R7", "bypass range", phy_bypass_hi, E_BYP[i]);
        chk(ac_dll_dis == 1 && dx_dll_dis == {LANES{1'b1}}, "R7", "DLL disables",
            {ac_dll_dis, dx_dll_dis}, {1'b1, {LANES{1'b1}}});
        for (int k = 0; k < 300 && sr_sw_req; k++) @(negedge clk);
        chk(sr_sw_req == 0, "R8", "self-refresh released", sr_sw_req, 0);
        repeat (4) @(negedge clk);
        chk(done == 0 && hif_disable == 1, "R8", "held until normal",
            {done, hif_disable}, 2'b01);
        if (V_AUTO_EXIT[i]) begin op_mode = 2'b11; sr_type = 2'b11; end
        else                begin op_mode = 2'b01; sr_type = 2'b00; end
        for (int k = 0; k < 300 && !done; k++) @(negedge clk);
        chk(done == 1 && err == 0, "R9", "completion", {done, err}, 2'b10);
        chk(hif_disable == 0, "R9", "host reopened", hif_disable, 0);
        chk(sw_done == 1, "R6", "window closed", sw_done, 1);
    endtask

    initial begin
        do_reset();
        chk(hif_disable == 0 && mrw_req == 0 && sr_sw_req == 0, "R1", "reset controls",
            {hif_disable, mrw_req, sr_sw_req}, 0);
        chk(sw_done == 1, "R1", "reset sw_done", sw_done, 1);
        chk(dll_off_mode == 0 && phy_bypass_hi == 0 && ac_dll_dis == 0 && dx_dll_dis == 0,
            "R1", "reset PHY bits", {dll_off_mode, phy_bypass_hi, ac_dll_dis, dx_dll_dis}, 0);
        chk(done == 0 && err == 0, "R1", "reset status", {done, err}, 0);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            run_vector(i);
        end

        // R10: a drain that never completes trips the watchdog.
        do_reset();
        pulse_start();
        repeat (WLIM - 24) @(negedge clk);
        chk(err == 0, "R10", "before limit", err, 0);
        repeat (48) @(negedge clk);
        chk(err == 1 && done == 0, "R10", "after limit", {err, done}, 2'b10);
        wr_pipe_empty = 1; rd_pipe_empty = 1; wrq_depth = 0; lprq_depth = 0; hprq_depth = 0;
        repeat (10) @(negedge clk);
        chk(err == 1 && n_mrw == 0, "R10", "sticky, no further step", {err, n_mrw[3:0]}, 5'h10);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule